// File: doc/BRIEF.md
# PCM Timeslot Serial Port

This block moves voice samples between a codec core and a time-division-multiplexed serial bus. An external bit clock drives it, and an external frame sync pulse marks the start of each frame. A running bit counter returns to zero on every frame sync and then counts bit clocks. When the count reaches a programmable transmit start value, the port shifts one parallel sample out of a tristatable line, most significant bit first. When the count reaches a separate receive start value, the port collects one sample from the receive line and presents it in parallel with a one-clock strobe.

The two start counts are given in bit clocks, not slot numbers. This lets one port serve long or short sync layouts and slot formats that do not fall on byte boundaries. A sample is normally 8 bits wide, and a 16-bit test format is also available. One select input chooses when the line is released after the last bit: half a clock early, so that the next talker in an adjacent slot can start without contention, or at the following rising edge. A start count that the frame never reaches turns that direction off without any other effect.

Top module: `pcm_slot_port`

## Requirements
- R1: A sampled-high `frameSync` at a rising edge makes the clock period that follows count 0. Each later rising edge adds one to the count. The count saturates at a value that no start count can match.
- R2: The transmit window starts in the period whose count equals `txStart`. In 8-bit format it carries bits 7..0 of the latched sample, and in 16-bit format bits 15..0. One bit goes out per period, most significant first, and `txData` changes only at rising edges.
- R3: The transmit sample is taken from `txSample` at the rising edge where `frameSync` is high. Later changes of `txSample` within the frame do not alter the bits sent.
- R4: `txOe` is low outside the transmit window. With `releaseEarly`=1 it falls at the falling edge in the middle of the last bit. With `releaseEarly`=0 it stays high for the whole last period.
- R5: Receive bits are sampled at falling edges during the periods whose counts run from `rxStart` to `rxStart`+width-1, most significant first. `rxValid` is high for exactly the one period that follows the window. `rxWord` is zero-extended in 8-bit format.
- R6: A start count larger than the last count reached in a frame gives no transmit drive and no receive strobe for that direction.
- R7: While `enable` is low, `txOe` stays low and `rxValid` never rises.
- R8: The transmit and receive start counts act independently. A start count of 0 places the first bit in the period right after the sync edge, and the sample latched at that same edge is the one sent.
- R9: With `wideMode`=1 each window lasts 16 periods in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameSync | input | 1 | Frame sync, sampled at the rising edge |
| enable | input | 1 | Port enable |
| wideMode | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit samples |
| releaseEarly | input | 1 | 1 releases the line at the falling edge of the last bit |
| txStart | input | 10 | Transmit start count, in bit clocks |
| rxStart | input | 10 | Receive start count, in bit clocks |
| txSample | input | 16 | Parallel sample from the codec core |
| txData | output | 1 | Serial transmit data, valid while `txOe` is high |
| txOe | output | 1 | Transmit driver enable (line is high-impedance when low) |
| rxData | input | 1 | Serial receive data |
| rxWord | output | 16 | Last received sample |
| rxValid | output | 1 | One-clock strobe when a new receive sample is ready |

## Verification
The assertions take for granted that `rxStart` and `wideMode` do not change while `enable` is high. They also take for granted that no window is still open when a new frame sync arrives, so each window ends before the next frame begins. The stimulus meets these conditions: it changes any setting only after dropping `enable` for two clocks between frames, and it places every window inside a frame long enough to hold it. The scoreboard follows every bit period of each frame. It queues the receive word expected from each enabled frame and checks that no strobe appears when a frame is disabled or its start count is out of reach.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic txLoad;     // transmit window opens at this rising edge
    logic txAdvance;  // move to the next transmit bit at this rising edge
    logic txActive;   // a transmit window is open in the current period
    logic txAtLsb;    // the current period carries the last transmit bit
    logic rxShift;    // take in the bit sampled at the last falling edge
    logic rxFinish;   // this shift completes the receive sample
  } slotStrobe_t;

endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int CntW    = 10,
  parameter int SampleW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameSync,
  input  logic            enable,
  input  logic            wideMode,
  input  logic [CntW-1:0] txStart,
  input  logic [CntW-1:0] rxStart,
  output slotStrobe_t     strobe
);

  // One spare count bit, so that the saturated value never equals a start count.
  localparam int RunW  = CntW + 1;
  localparam int IdxW  = $clog2(SampleW) + 1;
  localparam int HalfW = SampleW / 2;

  logic [RunW-1:0] runCnt, nextCnt;
  logic [IdxW-1:0] txIdx, spanLast, rxLeft;
  logic            txOn, txHit, rxHit;

  always_comb begin
    if (frameSync)    nextCnt = '0;
    else if (&runCnt) nextCnt = runCnt;
    else              nextCnt = runCnt + 1'b1;
  end

  assign spanLast = wideMode ? IdxW'(SampleW - 1) : IdxW'(HalfW - 1);
  assign txHit    = enable && (nextCnt == {1'b0, txStart});
  assign rxHit    = (nextCnt == {1'b0, rxStart});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      txOn   <= 1'b0;
      txIdx  <= '0;
      rxLeft <= '0;
    end else begin
      runCnt <= nextCnt;
      if (txHit) begin
        txOn  <= 1'b1;
        txIdx <= spanLast;
      end else if (txOn) begin
        if (txIdx == '0) txOn <= 1'b0;
        else             txIdx <= txIdx - 1'b1;
      end
      if (rxHit)             rxLeft <= spanLast + 1'b1;
      else if (rxLeft != '0) rxLeft <= rxLeft - 1'b1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.txLoad    = txHit;
    strobe.txAdvance = txOn;
    strobe.txActive  = txOn;
    strobe.txAtLsb   = txOn && (txIdx == '0);
    strobe.rxShift   = (rxLeft != '0);
    strobe.rxFinish  = (rxLeft == IdxW'(1));
  end

  // R1: the count restarts after a sampled frame sync
  a_r1_count_restart: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (runCnt == '0));

  // R1: the count steps by one when no sync is present
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !(&runCnt)) |=> (runCnt == $past(runCnt) + 1'b1));

  // R2: a transmit window opens only in the period whose count equals the start value
  a_r2_tx_begin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOn) |-> (runCnt == {1'b0, $past(txStart)}));

  // R9: the transmit window lasts its full width once it has opened
  a_r9_window_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txOn && txIdx != '0 && !txHit) |=> txOn);

  // R5: the receive countdown never exceeds one sample width
  a_r5_rx_span: assert property (@(posedge clk) disable iff (!rstN)
    rxLeft <= IdxW'(SampleW));

endmodule

// File: rtl/pcm_slot_dpath.sv
module pcm_slot_dpath
  import pcm_slot_pkg::*;
#(
  parameter int SampleW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameSync,
  input  logic               enable,
  input  logic               wideMode,
  input  logic               releaseEarly,
  input  logic [SampleW-1:0] txSample,
  input  logic               rxData,
  input  slotStrobe_t        strobe,
  output logic               txData,
  output logic               txOe,
  output logic [SampleW-1:0] rxWord,
  output logic               rxValid
);

  localparam int HalfW = SampleW / 2;

  logic [SampleW-1:0] txHold, txShiftReg, txSrc, rxShiftReg, rxNext;
  logic               rxBitN, cutN;

  // The narrow format places the low half at the top so the MSB leaves first.
  always_comb begin
    txSrc  = frameSync ? txSample : txHold;
    rxNext = {rxShiftReg[SampleW-2:0], rxBitN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold     <= '0;
      txShiftReg <= '0;
      rxShiftReg <= '0;
      rxWord     <= '0;
      rxValid    <= 1'b0;
    end else begin
      if (frameSync) txHold <= txSample;
      if (strobe.txLoad)
        txShiftReg <= wideMode ? txSrc : {txSrc[HalfW-1:0], {HalfW{1'b0}}};
      else if (strobe.txAdvance)
        txShiftReg <= {txShiftReg[SampleW-2:0], 1'b0};
      if (strobe.rxShift) rxShiftReg <= rxNext;
      if (strobe.rxFinish)
        rxWord <= wideMode ? rxNext : {{HalfW{1'b0}}, rxNext[HalfW-1:0]};
      rxValid <= strobe.rxFinish && enable;
    end
  end

  // Falling-edge side: receive sampling and the early-release marker.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBitN <= 1'b0;
      cutN   <= 1'b0;
    end else begin
      rxBitN <= rxData;
      cutN   <= strobe.txAtLsb;
    end
  end

  assign txOe   = enable && strobe.txActive && !(releaseEarly && cutN && strobe.txAtLsb);
  assign txData = txOe ? txShiftReg[SampleW-1] : 1'b0;

  // R7: no drive while the port is disabled
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !txOe);

  // R7: a receive strobe follows only an enabled cycle
  a_r7_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(enable));

  // R5: the receive strobe lasts one clock
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R4: the driver is enabled only inside an open transmit window
  a_r4_drive_in_window: assert property (@(posedge clk) disable iff (!rstN)
    txOe |-> strobe.txActive);

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int CntW    = 10,
  parameter int SampleW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameSync,
  input  logic               enable,
  input  logic               wideMode,
  input  logic               releaseEarly,
  input  logic [CntW-1:0]    txStart,
  input  logic [CntW-1:0]    rxStart,
  input  logic [SampleW-1:0] txSample,
  output logic               txData,
  output logic               txOe,
  input  logic               rxData,
  output logic [SampleW-1:0] rxWord,
  output logic               rxValid
);

  slotStrobe_t strobe;

  pcm_slot_ctrl #(.CntW(CntW), .SampleW(SampleW)) ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .enable(enable),
    .wideMode(wideMode), .txStart(txStart), .rxStart(rxStart), .strobe(strobe)
  );

  pcm_slot_dpath #(.SampleW(SampleW)) dpath (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .enable(enable),
    .wideMode(wideMode), .releaseEarly(releaseEarly), .txSample(txSample),
    .rxData(rxData), .strobe(strobe), .txData(txData), .txOe(txOe),
    .rxWord(rxWord), .rxValid(rxValid)
  );

endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic        enable = 1'b0;
  logic        wideMode = 1'b0;
  logic        releaseEarly = 1'b0;
  logic [9:0]  txStart = '0;
  logic [9:0]  rxStart = '0;
  logic [15:0] txSample = '0;
  logic        rxData = 1'b0;
  logic        txData, txOe, rxValid;
  logic [15:0] rxWord;

  int errors = 0;
  int checks = 0;
  logic [15:0] expQ[$];

  always #2.5 clk = ~clk;  // 200 MHz

  pcm_slot_port uut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .enable(enable),
    .wideMode(wideMode), .releaseEarly(releaseEarly), .txStart(txStart),
    .rxStart(rxStart), .txSample(txSample), .txData(txData), .txOe(txOe),
    .rxData(rxData), .rxWord(rxWord), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected receive word per strobe (R5).
  always @(posedge clk) begin
    #2;
    if (rstN && rxValid) begin
      if (expQ.size() == 0) check(1'b0, "R5 unexpected strobe", int'(rxWord), 0);
      else begin
        logic [15:0] want;
        want = expQ.pop_front();
        check(rxWord == want, "R5 received word", int'(rxWord), int'(want));
      end
    end
  end

  task automatic configure(input bit en, input bit wide, input bit early,
                           input int ts, input int rs);
    enable = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    wideMode = wide; releaseEarly = early;
    txStart = 10'(ts); rxStart = 10'(rs);
    enable = en;
  endtask

  // Driver: one frame of len periods, checks the line each half period.
  task automatic runFrame(input int len, input logic [15:0] txw,
                          input logic [15:0] rxw, input string tag);
    int w, s, rs;
    w = wideMode ? 16 : 8;
    s = int'(txStart);
    rs = int'(rxStart);
    frameSync = 1'b1;
    txSample = txw;
    rxData = 1'($urandom);
    if (enable && rs + w <= len)
      expQ.push_back(wideMode ? rxw : {8'h00, rxw[7:0]});
    @(posedge clk); #1;
    frameSync = 1'b0;
    txSample = 16'($urandom);  // R3: later changes must not reach the line
    for (int c = 0; c < len; c++) begin
      bit inTx, late;
      inTx = enable && c >= s && c < s + w;
      rxData = (c >= rs && c < rs + w) ? rxw[w-1-(c-rs)] : 1'($urandom);
      #1;
      check(txOe == inTx, {tag, " drive first half"}, int'(txOe), int'(inTx));
      if (inTx)
        check(txData == txw[w-1-(c-s)], {tag, " R2/R3 data bit"},
              int'(txData), int'(txw[w-1-(c-s)]));
      @(negedge clk); #1;
      late = inTx && !(releaseEarly && c == s + w - 1);
      check(txOe == late, {tag, " R4 drive second half"}, int'(txOe), int'(late));
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(txOe == 1'b0, "R4 reset drive", int'(txOe), 0);
    check(rxValid == 1'b0, "R5 reset strobe", int'(rxValid), 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1 and R2: short sync, start 1, late release
    configure(1'b1, 1'b0, 1'b0, 1, 3);
    runFrame(32, 16'h00A5, 16'h003C, "R1");
    runFrame(32, 16'h005A, 16'h00C3, "R2");
    // R4: early release
    configure(1'b1, 1'b0, 1'b1, 1, 3);
    runFrame(32, 16'h0081, 16'h007E, "R4");
    // R9: 16-bit windows
    configure(1'b1, 1'b1, 1'b0, 5, 10);
    runFrame(40, 16'hB00F, 16'h1234, "R9");
    runFrame(40, 16'h4C71, 16'hFEDC, "R9");
    // R8: both starts at 0, then independent placements at the frame end
    configure(1'b1, 1'b0, 1'b0, 0, 0);
    runFrame(32, 16'h00E7, 16'h0099, "R8");
    configure(1'b1, 1'b0, 1'b1, 24, 17);
    runFrame(32, 16'h0033, 16'h00F0, "R8");
    // R6: start counts never reached
    configure(1'b1, 1'b0, 1'b0, 100, 200);
    runFrame(32, 16'h00FF, 16'h00FF, "R6");
    // R7: disabled port
    configure(1'b0, 1'b0, 1'b0, 1, 3);
    runFrame(32, 16'h00FF, 16'h0055, "R7");

    repeat (4) @(posedge clk);
    #3;
    check(expQ.size() == 0, "R5 pending words", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule